// File: doc/BRIEF.md
# Wrapping Burst Column Address Generator

This block turns one burst request for a synchronous DRAM into the sequence of column addresses that the burst touches. A request carries a starting column, a 3-bit length code and an order select bit. The length is 2, 4 or 8 beats. The order is either sequential (counting upward) or interleaved (the beat number XORed into the start). The same sequence serves read bursts and write bursts.

After a start is accepted, the block presents one column address per clock. Each address comes with a valid flag, and the final address also carries a last flag. All addresses of a burst stay inside an aligned block whose size equals the burst length. The column bits above that block stay fixed for the whole burst, and the low bits wrap around without carrying upward.

A reserved length code produces no beats. Instead it raises a one-cycle error flag. Starts are taken only while no burst is in progress.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `valid_o`, `last_o` and `err_o` are low.
- R2: A start sampled while idle with `len_code_i` 3'b001, 3'b010 or 3'b011 produces 2, 4 or 8 valid beats respectively. The beats are on consecutive cycles, and beat 0 appears in the cycle after the clock edge that sampled the start.
- R3: With `xor_order_i` = 0 (sequential), beat n carries low offset (s + n) mod L, where s is the start column's offset within the block and L is the burst length.
- R4: With `xor_order_i` = 1 (interleaved), beat n carries low offset s XOR n.
- R5: The column bits at and above log2(L) equal those of the start column on every beat of the burst.
- R6: `last_o` is high only together with `valid_o`, and only on the final beat of the burst.
- R7: A start sampled while idle with any other length code (000, 100 to 111) produces no valid beat. It raises `err_o` for exactly the following cycle.
- R8: A start presented while a burst is in progress is ignored, including on its last-beat cycle. The earliest accepted new start is the one sampled on the cycle after the last beat.
- R9: Changes on `col_i`, `len_code_i` and `xor_order_i` during a burst do not affect the addresses, length or order of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new burst (taken only when idle) |
| col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst length code: 001=2, 010=4, 011=8, others reserved |
| xor_order_i | input | 1 | 0 = sequential order, 1 = interleaved order |
| valid_o | output | 1 | A burst beat is presented this cycle |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one of the burst |
| err_o | output | 1 | One-cycle pulse: a start with a reserved code was refused |

## Verification
The bench drives start columns whose low offsets sit at the top of the block, for example 3'b111 with length 8 and odd offsets with length 2. A design that let the offset carry into the upper column bits shows there as a wrong column on the wrapping beat. Starts are held high across the last-beat cycle to expose a design that re-arms one cycle early, which would lose the idle gap or drop a beat. Every reserved code is issued to catch a design that maps it to some length rather than refusing it. The length, order and column inputs are also toggled mid-burst to catch designs that read them live instead of latching them at the start.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    // Width of the in-block offset (largest burst is 8 beats)
    localparam int OFS_W = 3;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic              active;
        logic              err;
        order_e            order;
        logic [OFS_W-1:0]  beat;
        logic [OFS_W-1:0]  mask;   // L-1, also the final beat index
        logic [OFS_W-1:0]  first;  // start offset within block
    } ctl_t;

endpackage

// File: rtl/bl_decode.sv
module bl_decode
    import burst_col_pkg::*;
(
    input  logic [2:0]       code_i,
    output logic [OFS_W-1:0] mask_o,
    output logic             legal_o
);
    always_comb begin
        mask_o  = '0;
        legal_o = 1'b1;
        case (code_i)
            3'b001:  mask_o = 3'b001;
            3'b010:  mask_o = 3'b011;
            3'b011:  mask_o = 3'b111;
            default: legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/beat_offset.sv
module beat_offset
    import burst_col_pkg::*;
(
    input  logic [OFS_W-1:0] first_i,
    input  logic [OFS_W-1:0] beat_i,
    input  logic [OFS_W-1:0] mask_i,
    input  order_e           order_i,
    output logic [OFS_W-1:0] ofs_o
);
    logic [OFS_W-1:0] sum;
    logic [OFS_W-1:0] mix;

    always_comb begin
        sum = first_i + beat_i;
        mix = first_i ^ beat_i;
        ofs_o = ((order_i == ORD_XOR) ? mix : sum) & mask_i;
    end
endmodule

// File: rtl/col_merge.sv
module col_merge
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [OFS_W-1:0] mask_i,
    output logic [COL_W-1:0] col_o
);
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < OFS_W) begin : g_low
            assign col_o[i] = mask_i[i] ? ofs_i[i] : base_i[i];
        end else begin : g_high
            assign col_o[i] = base_i[i];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [2:0]       len_code_i,
    input  logic             xor_order_i,
    output logic             valid_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o,
    output logic             err_o
);
    ctl_t             ctl_d, ctl_q;
    logic [COL_W-1:0] base_d, base_q;
    logic [OFS_W-1:0] dec_mask;
    logic             dec_legal;
    logic [OFS_W-1:0] ofs;
    logic             at_end;

    bl_decode u_dec (
        .code_i  (len_code_i),
        .mask_o  (dec_mask),
        .legal_o (dec_legal)
    );

    beat_offset u_ofs (
        .first_i (ctl_q.first),
        .beat_i  (ctl_q.beat),
        .mask_i  (ctl_q.mask),
        .order_i (ctl_q.order),
        .ofs_o   (ofs)
    );

    col_merge #(.COL_W(COL_W)) u_merge (
        .base_i (base_q),
        .ofs_i  (ofs),
        .mask_i (ctl_q.mask),
        .col_o  (col_o)
    );

    assign at_end = ctl_q.active && (ctl_q.beat == ctl_q.mask);

    always_comb begin
        ctl_d     = ctl_q;
        base_d    = base_q;
        ctl_d.err = 1'b0;
        if (ctl_q.active) begin
            if (at_end) begin
                ctl_d.active = 1'b0;
            end else begin
                ctl_d.beat = ctl_q.beat + 1'b1;
            end
        end else if (start_i) begin
            if (dec_legal) begin
                ctl_d.active = 1'b1;
                ctl_d.beat   = '0;
                ctl_d.mask   = dec_mask;
                ctl_d.first  = col_i[OFS_W-1:0];
                ctl_d.order  = order_e'(xor_order_i);
                base_d       = col_i;
            end else begin
                ctl_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            base_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            base_q <= base_d;
        end
    end

    assign valid_o = ctl_q.active;
    assign last_o  = at_end;
    assign err_o   = ctl_q.err;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             valid_o,
    input logic [COL_W-1:0] col_o,
    input logic             last_o,
    input logic             err_o
);
    // R6
    last_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R7
    err_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o);

    // R2
    run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    // R5
    upper_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(col_o[COL_W-1:3]));

    // R8
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && start_i) |=> (!valid_o && !err_o));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_o (valid_o),
    .col_o   (col_o),
    .last_o  (last_o),
    .err_o   (err_o)
);

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] col_i = '0;
    logic [2:0]       len_code_i = 3'b000;
    logic             xor_order_i = 1'b0;
    logic             valid_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;
    logic             err_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R2";

    int exp_q[$];
    bit exp_err = 0;
    bit cur_xor = 0;

    always #4 clk = ~clk;

    burst_col_gen #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .len_code_i(len_code_i), .xor_order_i(xor_order_i),
        .valid_o(valid_o), .col_o(col_o), .last_o(last_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (%s) %s: actual %0d expected %0d", req, phase, what, act, exp);
        end
    endtask

    // Behavioural model update at a clock edge
    task automatic model_edge(input bit st, input int col, input int code, input bit il);
        int len;
        int blk;
        int off;
        exp_err = 0;
        if (exp_q.size() > 0) begin
            exp_q.delete(0);
        end else if (st) begin
            len = (code == 1) ? 2 : (code == 2) ? 4 : (code == 3) ? 8 : 0;
            if (len == 0) begin
                exp_err = 1;
            end else begin
                cur_xor = il;
                off = col % len;
                blk = col - off;
                for (int n = 0; n < len; n++)
                    exp_q.push_back(il ? blk + (off ^ n) : blk + ((off + n) % len));
            end
        end
    endtask

    task automatic compare();
        bit busy;
        busy = (exp_q.size() > 0);
        chk(valid_o == busy, "R2", "valid", int'(valid_o), int'(busy));
        if (busy) begin
            chk(int'(col_o) == exp_q[0], cur_xor ? "R4" : "R3", "col", int'(col_o), exp_q[0]);
            chk(int'(col_o >> 3) == (exp_q[0] >> 3), "R5", "upper col", int'(col_o >> 3), exp_q[0] >> 3);
        end
        chk(last_o == (exp_q.size() == 1), "R6", "last", int'(last_o), int'(exp_q.size() == 1));
        chk(err_o == exp_err, "R7", "err", int'(err_o), int'(exp_err));
    endtask

    task automatic cyc(input bit st, input int col, input int code, input bit il);
        start_i     = st;
        col_i       = COL_W'(col);
        len_code_i  = 3'(code);
        xor_order_i = il;
        @(posedge clk);
        model_edge(st, col, code, il);
        @(negedge clk);
        compare();
    endtask

    task automatic burst(input int col, input int code, input bit il);
        cyc(1, col, code, il);
        for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0);
    endtask

    initial begin
        int cols[6];
        cols = '{10'h3FF, 10'h005, 10'h2A2, 10'h107, 10'h000, 10'h1FB};
        // R1: reset state
        repeat (3) @(negedge clk);
        phase = "R1";
        chk(!valid_o && !last_o && !err_o, "R1", "outputs in reset", int'({valid_o, last_o, err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!valid_o && !last_o && !err_o, "R1", "outputs after reset", int'({valid_o, last_o, err_o}), 0);

        // R2 R3 R4 R5 R6: all lengths, both orders, offsets at block edges
        phase = "R2";
        for (int c = 1; c <= 3; c++)
            for (int il = 0; il < 2; il++)
                foreach (cols[i]) burst(cols[i], c, il[0]);

        // R7: every reserved code
        phase = "R7";
        foreach (cols[i]) begin
            cyc(1, cols[i], 0, 0);
            cyc(1, cols[i], 4, 1);
            cyc(0, 0, 0, 0);
            cyc(1, cols[i], 5, 0);
            cyc(1, cols[i], 6, 1);
            cyc(1, cols[i], 7, 0);
            cyc(0, 0, 0, 0);
        end

        // R8: start held high continuously, changing requests each cycle
        phase = "R8";
        for (int k = 0; k < 60; k++) cyc(1, (k * 37) % 1024, 1 + (k % 3), k[0]);
        for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0);

        // R9: inputs toggled during bursts, random sweep
        phase = "R9";
        for (int k = 0; k < 300; k++) begin
            cyc(($urandom % 3) != 0, int'($urandom % 1024), int'($urandom % 8), 1'($urandom));
        end
        for (int k = 0; k < 9; k++) cyc(0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog (%s): actual timeout expected completion", phase);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule